// File: doc/BRIEF.md
# Cassette FSK Tape Decoder

This block recovers a recorded data record from a cassette playback signal. An external comparator has already squared the signal into a single logic bit. The block first brings that bit into the clock domain. It then counts sample periods between pairs of input transitions, so each measurement covers one full cycle of the recorded waveform. Each full-cycle width is classified as a lead-in tone cycle, a start marker, a short data cycle or a long data cycle.

Software or a controlling state machine loads the expected data length and pulses `start`. The decoder then waits for a long enough run of lead-in tone cycles and takes the first short marker cycle after that run as the start of data. It assembles bits into bytes with the most significant bit first. Each of the requested data bytes is delivered with a one-clock strobe. The byte that follows is treated as a checksum: it is compared against the XOR of all data bytes and is never delivered as data. A one-clock done pulse closes the record. The checksum-error flag then holds its verdict until the next start.

All widths are expressed in sample periods of `SAMPLE_DIV` clocks. With the default thresholds, a sample period of 10 µs places the data-0 cycle near 50 samples, the data-1 cycle near 100, the lead-in cycle near 130 and the marker near 40.

Top module: `tape_fsk_rx`

## Requirements
- R1: After reset, `byte_vld`, `rec_done` and `cks_err` are low, and no byte or done pulse appears until a `start` pulse has been given.
- R2: In the data phase, a full cycle measuring fewer than `BIT_LIM` samples decodes as bit 0, and a cycle of `BIT_LIM` samples or more decodes as bit 1.
- R3: The first bit received after the marker, and after every completed byte, is bit 7 of the byte (most significant bit first).
- R4: A marker cycle (fewer than `SYNC_LIM` samples) opens the data phase only if it follows at least `HDR_CYCLES` consecutive lead-in cycles, each measuring from `HDR_LO` to `HDR_HI` samples inclusive. With fewer lead-in cycles, no byte and no done pulse follow.
- R5: Any cycle outside the lead-in band, including a marker that arrives too early, resets the run of lead-in cycles to zero.
- R6: Exactly `rec_len` bytes, as sampled at `start`, are delivered. Each is marked by a `byte_vld` pulse that lasts one clock, with the byte on `byte_out`.
- R7: The byte after the last data byte is the checksum. It raises no `byte_vld`, and it produces a one-clock `rec_done` pulse, after which the decoder ignores the input until the next start.
- R8: `cks_err` is set together with `rec_done` when the checksum differs from the XOR of the delivered bytes and cleared when they match. It keeps that value until the next `start`, which clears it.
- R9: Cycles arriving while the decoder is idle (before any start, or after a done pulse) produce no output.
- R10: With `rec_len` equal to zero, the first byte after the marker is the checksum and is compared against zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tape_in | input | 1 | Squared playback signal, asynchronous |
| start | input | 1 | One-clock pulse that arms a new record and samples `rec_len` |
| rec_len | input | LEN_W | Number of data bytes expected before the checksum |
| byte_vld | output | 1 | One-clock strobe marking a delivered data byte |
| byte_out | output | 8 | Data byte, valid while `byte_vld` is high |
| rec_done | output | 1 | One-clock pulse after the checksum byte |
| cks_err | output | 1 | Checksum verdict of the last record, held until the next start |

## Verification
If the lead-in run counter or the edge pairing is wrong, the whole record is lost: either no byte and no done pulse appear, or bytes appear after a lead-in that is too short. This shows at the ports within the first byte time after the marker. If the byte counter or the bit counter is off by one, the checksum either leaks out as an extra strobed byte or a data byte is swallowed. In both cases the error shows as a wrong byte count and a set `cks_err` by the time `rec_done` fires. An error in classification or bit order corrupts specific byte values at their own strobe, so the bench uses asymmetric bytes and cycle widths just on either side of the bit threshold.

// File: rtl/tape_rx_pkg.sv
// Shared types for the cassette decoder.
// Assumes: nothing beyond the standard language.
package tape_rx_pkg;

    // Phase of the record decoder.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // ignoring the input
        ST_HUNT = 2'd1,   // counting lead-in cycles, waiting for the marker
        ST_DATA = 2'd2    // assembling data and checksum bytes
    } rx_state_e;

endpackage

// File: rtl/tape_in_sync.sv
// Multi-stage synchroniser for the asynchronous tape input.
// Assumes: the input is a slow single-bit level (kHz range) relative to clk.
module tape_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // Shift the raw level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], din};
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/tape_cycle_timer.sv
// Full-cycle width meter. It counts sample ticks (one per SAMPLE_DIV
// clocks) and pairs input transitions: every second transition closes a
// cycle, reports its width and restarts the count.
// Assumes: after rephase, the first transition is a cycle boundary. The
// width saturates at its all-ones value.
module tape_cycle_timer #(
    parameter int SAMPLE_DIV = 1250,
    parameter int CNT_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rephase,
    input  logic             lvl,
    output logic             cyc_stb,
    output logic [CNT_W-1:0] cyc_len
);
    localparam int DIV_W = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SAMPLE_DIV - 1);
    localparam logic [CNT_W-1:0] CNT_SAT  = '1;

    logic             lvl_q;
    logic             primed;
    logic             mid;
    logic [DIV_W-1:0] pre, pre_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic             tick, edge_seen;

    // Next values of the prescaler and the saturating width counter.
    always_comb begin
        tick      = (pre == DIV_LAST);
        pre_nx    = tick ? '0 : pre + 1'b1;
        cnt_nx    = (tick && (cnt != CNT_SAT)) ? cnt + 1'b1 : cnt;
        edge_seen = lvl ^ lvl_q;
    end

    // Pair transitions into full cycles and report each closed cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q   <= 1'b0;
            primed  <= 1'b0;
            mid     <= 1'b0;
            pre     <= '0;
            cnt     <= '0;
            cyc_stb <= 1'b0;
            cyc_len <= '0;
        end else begin
            lvl_q   <= lvl;
            cyc_stb <= 1'b0;
            if (rephase) begin
                primed <= 1'b0;
                mid    <= 1'b0;
                pre    <= '0;
                cnt    <= '0;
            end else if (edge_seen) begin
                if (!primed) begin
                    primed <= 1'b1;
                    mid    <= 1'b0;
                    pre    <= '0;
                    cnt    <= '0;
                end else if (mid) begin
                    cyc_stb <= 1'b1;
                    cyc_len <= cnt_nx;
                    mid     <= 1'b0;
                    pre     <= '0;
                    cnt     <= '0;
                end else begin
                    mid <= 1'b1;
                    pre <= pre_nx;
                    cnt <= cnt_nx;
                end
            end else begin
                pre <= pre_nx;
                cnt <= cnt_nx;
            end
        end
    end
endmodule

// File: rtl/tape_cycle_class.sv
// Combinational classifier for one measured cycle width.
// Assumes: SYNC_LIM < BIT_LIM < HDR_LO <= HDR_HI, all in sample ticks.
module tape_cycle_class #(
    parameter int CNT_W    = 8,
    parameter int SYNC_LIM = 45,
    parameter int BIT_LIM  = 75,
    parameter int HDR_LO   = 115,
    parameter int HDR_HI   = 150
) (
    input  logic [CNT_W-1:0] len,
    output logic             is_sync,
    output logic             is_hdr,
    output logic             bit_val
);
    // Compare the width against the three bands.
    always_comb begin
        is_sync = (len < CNT_W'(SYNC_LIM));
        is_hdr  = (len >= CNT_W'(HDR_LO)) && (len <= CNT_W'(HDR_HI));
        bit_val = (len >= CNT_W'(BIT_LIM));
    end
endmodule

// File: rtl/tape_frame_fsm.sv
// Record sequencer: lead-in run counting, marker detection, MSB-first
// byte assembly, byte delivery and the checksum check.
// Assumes: at most one classified cycle per clock, on cyc_stb.
module tape_frame_fsm
    import tape_rx_pkg::*;
#(
    parameter int LEN_W      = 16,
    parameter int HDR_CYCLES = 500
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] exp_len,
    input  logic             cyc_stb,
    input  logic             is_sync,
    input  logic             is_hdr,
    input  logic             bit_val,
    output logic             byte_vld,
    output logic [7:0]       byte_out,
    output logic             rec_done,
    output logic             cks_err
);
    localparam int HC_W = $clog2(HDR_CYCLES + 1);
    localparam logic [HC_W-1:0] HC_ARM = HC_W'(HDR_CYCLES);

    rx_state_e        st;
    logic [HC_W-1:0]  hdr_n;
    logic [2:0]       bit_n;
    logic [7:0]       shreg;
    logic [7:0]       acc;
    logic [LEN_W-1:0] byte_n;
    logic [LEN_W-1:0] len_q;
    logic [7:0]       assembled;
    logic             armed;

    // Byte formed if the current bit is appended, and the arming state.
    always_comb begin
        assembled = {shreg[6:0], bit_val};
        armed     = (hdr_n >= HC_ARM);
    end

    // Advance the record state on each start pulse and each classified cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            hdr_n    <= '0;
            bit_n    <= '0;
            shreg    <= '0;
            acc      <= '0;
            byte_n   <= '0;
            len_q    <= '0;
            byte_vld <= 1'b0;
            byte_out <= '0;
            rec_done <= 1'b0;
            cks_err  <= 1'b0;
        end else begin
            byte_vld <= 1'b0;
            rec_done <= 1'b0;
            if (start) begin
                st      <= ST_HUNT;
                hdr_n   <= '0;
                cks_err <= 1'b0;
                len_q   <= exp_len;
            end else if (cyc_stb) begin
                case (st)
                    ST_HUNT: begin
                        if (is_sync && armed) begin
                            st     <= ST_DATA;
                            bit_n  <= '0;
                            byte_n <= '0;
                            acc    <= '0;
                        end else if (is_hdr) begin
                            if (!armed) hdr_n <= hdr_n + 1'b1;
                        end else begin
                            hdr_n <= '0;
                        end
                    end
                    ST_DATA: begin
                        shreg <= assembled;
                        bit_n <= bit_n + 1'b1;
                        if (bit_n == 3'd7) begin
                            if (byte_n == len_q) begin
                                rec_done <= 1'b1;
                                cks_err  <= (assembled != acc);
                                st       <= ST_IDLE;
                            end else begin
                                byte_vld <= 1'b1;
                                byte_out <= assembled;
                                acc      <= acc ^ assembled;
                                byte_n   <= byte_n + 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/tape_fsk_rx.sv
// Top of the cassette decoder: synchroniser, cycle meter, classifier
// and record sequencer in a chain.
// Assumes: tape_in is already squared; thresholds are in sample ticks.
module tape_fsk_rx #(
    parameter int SAMPLE_DIV = 1250,
    parameter int HDR_CYCLES = 500,
    parameter int SYNC_LIM   = 45,
    parameter int BIT_LIM    = 75,
    parameter int HDR_LO     = 115,
    parameter int HDR_HI     = 150,
    parameter int LEN_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tape_in,
    input  logic             start,
    input  logic [LEN_W-1:0] rec_len,
    output logic             byte_vld,
    output logic [7:0]       byte_out,
    output logic             rec_done,
    output logic             cks_err
);
    localparam int CNT_W = $clog2(HDR_HI + 2);

    logic             lvl;
    logic             cyc_stb;
    logic [CNT_W-1:0] cyc_len;
    logic             is_sync, is_hdr, bit_val;

    tape_in_sync #(.STAGES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (tape_in),
        .dout (lvl)
    );

    tape_cycle_timer #(.SAMPLE_DIV(SAMPLE_DIV), .CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .rephase(start),
        .lvl    (lvl),
        .cyc_stb(cyc_stb),
        .cyc_len(cyc_len)
    );

    tape_cycle_class #(
        .CNT_W(CNT_W), .SYNC_LIM(SYNC_LIM), .BIT_LIM(BIT_LIM),
        .HDR_LO(HDR_LO), .HDR_HI(HDR_HI)
    ) u_class (
        .len    (cyc_len),
        .is_sync(is_sync),
        .is_hdr (is_hdr),
        .bit_val(bit_val)
    );

    tape_frame_fsm #(.LEN_W(LEN_W), .HDR_CYCLES(HDR_CYCLES)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .exp_len (rec_len),
        .cyc_stb (cyc_stb),
        .is_sync (is_sync),
        .is_hdr  (is_hdr),
        .bit_val (bit_val),
        .byte_vld(byte_vld),
        .byte_out(byte_out),
        .rec_done(rec_done),
        .cks_err (cks_err)
    );
endmodule

// File: rtl/tape_rx_chk.sv
// Property checker for tape_fsk_rx, attached by bind. It keeps its own
// count of strobed bytes since the last start.
// Assumes: start is not raised in the same clock as a strobe.
module tape_rx_chk #(
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [LEN_W-1:0] rec_len,
    input logic             byte_vld,
    input logic             rec_done,
    input logic             cks_err
);
    logic [LEN_W:0]   seen;
    logic [LEN_W-1:0] len_q;

    // Track the requested length and the number of bytes delivered so far.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen  <= '0;
            len_q <= '0;
        end else if (start) begin
            seen  <= '0;
            len_q <= rec_len;
        end else if (byte_vld) begin
            seen <= seen + 1'b1;
        end
    end

    AST_VLD_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |=> !byte_vld); // R6
    AST_DONE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        rec_done |=> !rec_done); // R7
    AST_NO_VLD_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_vld && rec_done)); // R7
    AST_VLD_WITHIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> (seen < {1'b0, len_q})); // R6
    AST_DONE_AT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        rec_done |-> (seen == {1'b0, len_q})); // R6
    AST_ERR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (cks_err != $past(cks_err)) |-> (rec_done || $past(start))); // R8
endmodule

bind tape_fsk_rx tape_rx_chk #(.LEN_W(LEN_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .rec_len (rec_len),
    .byte_vld(byte_vld),
    .rec_done(rec_done),
    .cks_err (cks_err)
);

// File: tb/sim_tape_fsk_rx.sv
`timescale 1ns/1ps
module sim_tape_fsk_rx;
    localparam int DIV  = 2;
    localparam int HDRN = 6;
    localparam int LW   = 16;
    localparam int H0   = 25;   // half width of a data-0 cycle, samples
    localparam int H1   = 50;   // half width of a data-1 cycle
    localparam int HH   = 65;   // half width of a lead-in cycle
    localparam int HS   = 20;   // half width of the marker cycle

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tape = 1'b0;
    logic          start = 1'b0;
    logic [LW-1:0] rec_len = '0;
    logic          byte_vld, rec_done, cks_err;
    logic [7:0]    byte_out;

    int n_chk = 0;
    int n_fail = 0;
    int rx_n = 0;
    int done_n = 0;
    logic [7:0] rx_buf [0:31];
    logic [7:0] txb [0:15];
    bit finished = 0;

    always #4 clk = ~clk;

    tape_fsk_rx #(
        .SAMPLE_DIV(DIV), .HDR_CYCLES(HDRN), .LEN_W(LW)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .tape_in(tape), .start(start),
        .rec_len(rec_len), .byte_vld(byte_vld), .byte_out(byte_out),
        .rec_done(rec_done), .cks_err(cks_err)
    );

    // Collect strobed bytes and done pulses away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (byte_vld) begin
                if (rx_n < 32) rx_buf[rx_n] <= byte_out;
                rx_n <= rx_n + 1;
            end
            if (rec_done) done_n <= done_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic half(input int n);
        repeat (n * DIV) @(negedge clk);
        tape = ~tape;
    endtask

    task automatic cyc(input int h);
        half(h);
        half(h);
    endtask

    task automatic send_byte(input logic [7:0] b, input int h0, input int h1);
        for (int i = 7; i >= 0; i--) cyc(b[i] ? h1 : h0);
    endtask

    task automatic do_start(input int len);
        repeat (4) @(negedge clk);
        rec_len = LW'(len);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // Boundary edge, nhdr lead-in cycles, marker, n bytes of txb, checksum ^ mod.
    task automatic send_rec(input int nhdr, input int n, input logic [7:0] mod,
                            input int h0, input int h1);
        logic [7:0] x;
        x = 8'h00;
        tape = ~tape;
        for (int i = 0; i < nhdr; i++) cyc(HH);
        cyc(HS);
        for (int i = 0; i < n; i++) begin
            send_byte(txb[i], h0, h1);
            x = x ^ txb[i];
        end
        send_byte(x ^ mod, h0, h1);
        repeat (30) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(byte_vld == 1'b0, "R1", "byte_vld after reset", byte_vld, 0);
        chk(rec_done == 1'b0, "R1", "rec_done after reset", rec_done, 0);
        chk(cks_err == 1'b0, "R1", "cks_err after reset", cks_err, 0);
    endtask

    // R9: a record with no start gives no output
    task automatic t_idle_first();
        int b0, d0;
        b0 = rx_n; d0 = done_n;
        txb[0] = 8'h5A;
        send_rec(HDRN + 1, 1, 8'h00, H0, H1);
        chk(rx_n == b0, "R9", "bytes while idle", rx_n - b0, 0);
        chk(done_n == d0, "R9", "done while idle", done_n - d0, 0);
    endtask

    task automatic t_basic();
        int b0, d0;
        b0 = rx_n; d0 = done_n;
        txb[0] = 8'h1E; txb[1] = 8'h80; txb[2] = 8'hFF; txb[3] = 8'h06;
        do_start(4);
        send_rec(HDRN + 2, 4, 8'h00, H0, H1);
        chk(rx_n - b0 == 4, "R6", "byte count", rx_n - b0, 4);
        chk(rx_buf[b0] == 8'h1E, "R3", "byte 0 msb first", rx_buf[b0], 8'h1E);
        chk(rx_buf[b0+1] == 8'h80, "R3", "byte 1 msb first", rx_buf[b0+1], 8'h80);
        chk(rx_buf[b0+2] == 8'hFF, "R2", "all ones byte", rx_buf[b0+2], 8'hFF);
        chk(rx_buf[b0+3] == 8'h06, "R2", "byte 3", rx_buf[b0+3], 8'h06);
        chk(done_n - d0 == 1, "R7", "done pulses", done_n - d0, 1);
        chk(cks_err == 1'b0, "R8", "good checksum", cks_err, 0);
        // R9: after done, another record without start is ignored
        b0 = rx_n; d0 = done_n;
        send_rec(HDRN, 2, 8'h00, H0, H1);
        chk(rx_n == b0, "R9", "bytes after done", rx_n - b0, 0);
        chk(done_n == d0, "R9", "done after done", done_n - d0, 0);
    endtask

    task automatic t_badcks();
        int b0, d0;
        b0 = rx_n; d0 = done_n;
        txb[0] = 8'h01; txb[1] = 8'h02; txb[2] = 8'h04;
        do_start(3);
        send_rec(HDRN, 3, 8'h07, H0, H1);
        chk(rx_n - b0 == 3, "R7", "checksum not delivered", rx_n - b0, 3);
        chk(done_n - d0 == 1, "R7", "done on bad record", done_n - d0, 1);
        chk(cks_err == 1'b1, "R8", "bad checksum flagged", cks_err, 1);
        repeat (300) @(negedge clk);
        chk(cks_err == 1'b1, "R8", "flag held", cks_err, 1);
        do_start(1);
        chk(cks_err == 1'b0, "R8", "flag cleared by start", cks_err, 0);
    endtask

    task automatic t_short_hdr();
        int b0, d0;
        b0 = rx_n; d0 = done_n;
        txb[0] = 8'h33; txb[1] = 8'h44;
        do_start(2);
        send_rec(HDRN - 1, 2, 8'h00, H0, H1);
        chk(rx_n == b0, "R4", "bytes after short lead-in", rx_n - b0, 0);
        chk(done_n == d0, "R4", "done after short lead-in", done_n - d0, 0);
    endtask

    task automatic t_broken_hdr();
        int b0, d0;
        logic [7:0] x;
        b0 = rx_n; d0 = done_n;
        txb[0] = 8'hC4; txb[1] = 8'h29;
        do_start(2);
        tape = ~tape;
        for (int i = 0; i < HDRN - 1; i++) cyc(HH);
        cyc(45);                         // out-of-band cycle breaks the run
        for (int i = 0; i < HDRN - 1; i++) cyc(HH);
        cyc(HS);
        x = txb[0] ^ txb[1];
        send_byte(txb[0], H0, H1);
        send_byte(txb[1], H0, H1);
        send_byte(x, H0, H1);
        repeat (30) @(negedge clk);
        chk(rx_n == b0, "R5", "bytes after broken lead-in", rx_n - b0, 0);
        chk(done_n == d0, "R5", "done after broken lead-in", done_n - d0, 0);
        do_start(2);
        send_rec(HDRN, 2, 8'h00, H0, H1);
        chk(rx_n - b0 == 2, "R4", "exact lead-in count accepted", rx_n - b0, 2);
        chk(rx_buf[b0+1] == 8'h29, "R4", "byte after exact lead-in", rx_buf[b0+1], 8'h29);
    endtask

    task automatic t_zero_len();
        int b0, d0;
        b0 = rx_n; d0 = done_n;
        do_start(0);
        send_rec(HDRN, 0, 8'h00, H0, H1);
        chk(rx_n == b0, "R10", "no bytes for zero length", rx_n - b0, 0);
        chk(done_n - d0 == 1, "R10", "done for zero length", done_n - d0, 1);
        chk(cks_err == 1'b0, "R10", "zero checksum accepted", cks_err, 0);
        do_start(0);
        send_rec(HDRN, 0, 8'h5A, H0, H1);
        chk(cks_err == 1'b1, "R10", "nonzero checksum flagged", cks_err, 1);
    endtask

    task automatic t_threshold();
        int b0;
        b0 = rx_n;
        txb[0] = 8'h69;
        do_start(1);
        send_rec(HDRN, 1, 8'h00, 35, 40);  // 70 vs 80 samples around BIT_LIM
        chk(rx_n - b0 == 1, "R2", "near-threshold byte count", rx_n - b0, 1);
        chk(rx_buf[b0] == 8'h69, "R2", "near-threshold bits", rx_buf[b0], 8'h69);
        chk(cks_err == 1'b0, "R2", "near-threshold checksum", cks_err, 0);
    endtask

    initial begin
        #1520000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_idle_first();
        t_basic();
        t_badcks();
        t_short_hdr();
        t_broken_hdr();
        t_zero_len();
        t_threshold();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule